// File: doc/BRIEF.md
# Key-Controlled Watchdog Timer

This block is a watchdog that software controls through a four-location register bank on a plain synchronous bus (address, write data, write strobe, read strobe, registered read data). Software first stores a timeout, counted in periods of an external slow tick, then arms the watchdog by writing an arm key to the control location. A disarm key stops it. While armed, the block counts down one step per tick. When the count runs out, it drives a reset pulse of fixed length, sets a sticky expiry flag and falls back to the disarmed state.

Refreshing the watchdog is strict. A disarm key followed by an arm key reloads the counter from the stored timeout. Writing a new timeout or repeating the arm key does not reload it. If the watchdog is armed while the timeout has not been written since the last expiry or standby reset, or while it holds zero, the block expires at once. The enable, the flag, the timeout and the counter sit in the standby domain. The main reset clears only the bus read path.

Top module: `kwdt_top`

## Requirements
- R1: Writing 0x55 to address 0 while disarmed arms the watchdog, and writing 0xAA to address 0 disarms it. When several keys are written in turn, the latest one decides. The enable is readable as bit 0 of address 0 and as bit 0 of the status word at address 2.
- R2: A write to address 0 with any value other than 0x55 or 0xAA leaves the enable unchanged.
- R3: Arming from the disarmed state with a written, non-zero timeout (address 1) loads the counter from that timeout. The counter can be read at address 3.
- R4: While armed, each tick lowers the counter by one. A tick that arrives while the counter is 1 causes an expiry.
- R5: Writing address 1 while armed updates the stored timeout, readable at address 1, but leaves the running counter unchanged.
- R6: Writing 0x55 while already armed leaves the counter unchanged.
- R7: Arming when the timeout has not been written since the last expiry or standby reset, or when the timeout is zero, expires in that same cycle.
- R8: An expiry sets the sticky flag (status bit 1) and disarms the watchdog. It also drives the reset output high for PULSE_CYCLES consecutive cycles, starting in the cycle after the expiry edge.
- R9: Reading address 2 returns the flag, and the flag is clear from the next cycle. If an expiry occurs in the same cycle as that read, the flag stays set.
- R10: If a disarm-key write falls in the same cycle as the terminal tick, there is no expiry and no reset pulse.
- R11: The main reset clears only the read data. The enable, flag, timeout and counter survive it. The standby reset clears all state, and after it all readable values are zero.
- R12: Read data is registered. It appears in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sb_rst_n | input | 1 | Standby-domain reset, active low, clears all state |
| sys_rst_n | input | 1 | Main reset, active low, clears the read data only |
| tick | input | 1 | One-cycle time-base pulse that paces the countdown |
| bus_addr | input | 2 | Register address: 0 control, 1 timeout, 2 status, 3 counter |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| wdt_rst_out | output | 1 | Reset pulse produced on expiry |

## Verification
Two pairs of events can land in the same cycle. The first pair is a status read and an expiry. The second is a terminal tick and a disarm-key write. The bench forces each pair with directed cycles: a read strobe issued together with the tick that takes the counter from 1, and a 0xAA write issued together with that same tick. The first case is judged by checking that the read returns the old flag and a following read shows the flag still set. The second is judged by checking that the reset output stays low and the status word reads zero. Random traffic with small timeouts and frequent ticks then makes these and other collisions happen again, and every cycle is compared against a bench model.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DATA_W = 8;
  typedef logic [DATA_W-1:0] word_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TMO  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_CNT  = 2'd3;

  localparam word_t KEY_ARM    = 8'h55;
  localparam word_t KEY_DISARM = 8'hAA;

  // status layout: bit0 enable, bit1 sticky expiry flag
  function automatic word_t stat_word(input logic en, input logic flg);
    stat_word = {{(DATA_W-2){1'b0}}, flg, en};
  endfunction

  // a reload is usable only when written since last expiry and non-zero
  function automatic logic reload_ok(input logic valid, input word_t tmo);
    reload_ok = valid && (tmo != '0);
  endfunction

  function automatic word_t dec_count(input word_t c);
    dec_count = (c == '0) ? '0 : c - 1'b1;
  endfunction
endpackage

// File: rtl/kwdt_regbank.sv
module kwdt_regbank
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       sb_rst_n,
  input  logic       sys_rst_n,
  input  logic [1:0] addr,
  input  word_t      wdata,
  input  logic       wr,
  input  logic       rd,
  input  logic       fire,
  input  word_t      cnt,
  output word_t      rdata,
  output logic       en,
  output word_t      tmo,
  output logic       tmo_valid,
  output logic       arm_req,
  output logic       disarm_req
);
  logic wr_ctrl, arm_key, rd_stat, wr_tmo, flag;

  assign wr_ctrl    = wr && (addr == A_CTRL);
  assign arm_key    = wr_ctrl && (wdata == KEY_ARM);
  assign disarm_req = wr_ctrl && (wdata == KEY_DISARM);
  assign arm_req    = arm_key && !en;
  assign wr_tmo     = wr && (addr == A_TMO);
  assign rd_stat    = rd && (addr == A_STAT);

  // standby-domain state
  always_ff @(posedge clk or negedge sb_rst_n) begin
    if (!sb_rst_n) begin
      en        <= 1'b0;
      flag      <= 1'b0;
      tmo       <= '0;
      tmo_valid <= 1'b0;
    end else begin
      if (fire)            en <= 1'b0;
      else if (arm_req)    en <= 1'b1;
      else if (disarm_req) en <= 1'b0;

      if (fire)         flag <= 1'b1;
      else if (rd_stat) flag <= 1'b0;

      if (wr_tmo) tmo <= wdata;

      if (fire)        tmo_valid <= 1'b0;
      else if (wr_tmo) tmo_valid <= 1'b1;
    end
  end

  // main-domain read path
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        A_CTRL:  rdata <= stat_word(en, 1'b0);
        A_TMO:   rdata <= tmo;
        A_STAT:  rdata <= stat_word(en, flag);
        default: rdata <= cnt;
      endcase
    end
  end

  // R8
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
    fire |=> (flag && !en));
  // R9
  read_clears_flag_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (rd_stat && !fire) |=> !flag);
  // R1
  disarm_wins_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
    disarm_req |=> !en);
  // R2
  junk_key_ignored_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (wr_ctrl && !arm_key && !disarm_req && !fire) |=> (en == $past(en)));
  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !sb_rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/kwdt_countdown.sv
module kwdt_countdown
  import kwdt_pkg::*;
(
  input  logic  clk,
  input  logic  sb_rst_n,
  input  logic  en,
  input  logic  tick,
  input  logic  arm_req,
  input  logic  disarm_req,
  input  word_t tmo,
  input  logic  tmo_valid,
  output word_t cnt,
  output logic  fire
);
  logic imm_fire, load, step, tick_fire;

  assign imm_fire  = arm_req && !reload_ok(tmo_valid, tmo);
  assign load      = arm_req && !imm_fire;
  assign step      = en && tick && !disarm_req;
  assign tick_fire = step && (cnt == word_t'(1));
  assign fire      = imm_fire || tick_fire;

  always_ff @(posedge clk or negedge sb_rst_n) begin
    if (!sb_rst_n)  cnt <= '0;
    else if (fire)  cnt <= '0;
    else if (load)  cnt <= tmo;
    else if (step)  cnt <= dec_count(cnt);
  end

  // R4
  tick_decrements_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (step && cnt > word_t'(1)) |=> (cnt == $past(cnt) - 1'b1));
  // R3
  arm_loads_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
    load |=> (cnt == $past(tmo)));
  // R5
  armed_no_reload_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (en && !tick) |=> $stable(cnt));
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic sb_rst_n,
  input  logic fire,
  output logic rst_out
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge sb_rst_n) begin
    if (!sb_rst_n)        pcnt <= '0;
    else if (fire)        pcnt <= PW'(PULSE_CYCLES);
    else if (pcnt != '0)  pcnt <= pcnt - 1'b1;
  end

  assign rst_out = (pcnt != '0);

  // R8
  pulse_starts_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
    fire |=> rst_out);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       sb_rst_n,
  input  logic       sys_rst_n,
  input  logic       tick,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  output logic       wdt_rst_out
);
  logic  en, tmo_valid, arm_req, disarm_req, fire;
  word_t tmo, cnt;

  kwdt_regbank u_regs (
    .clk(clk), .sb_rst_n(sb_rst_n), .sys_rst_n(sys_rst_n),
    .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr), .rd(bus_rd),
    .fire(fire), .cnt(cnt), .rdata(bus_rdata), .en(en), .tmo(tmo),
    .tmo_valid(tmo_valid), .arm_req(arm_req), .disarm_req(disarm_req)
  );

  kwdt_countdown u_cnt (
    .clk(clk), .sb_rst_n(sb_rst_n), .en(en), .tick(tick),
    .arm_req(arm_req), .disarm_req(disarm_req), .tmo(tmo),
    .tmo_valid(tmo_valid), .cnt(cnt), .fire(fire)
  );

  kwdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .sb_rst_n(sb_rst_n), .fire(fire), .rst_out(wdt_rst_out)
  );

  // R7
  stale_arm_fires_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (arm_req && !tmo_valid) |=> wdt_rst_out);
  // R10
  disarm_beats_tick_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
    (disarm_req && !wdt_rst_out) |=> !wdt_rst_out);
endmodule

// File: tb/kwdt_top_bench.sv
module kwdt_top_bench;
  localparam int PULSE = 4;
  logic clk = 1'b0;
  logic sb_rst_n = 1'b0, sys_rst_n = 1'b0, tick = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic rst_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic m_en, m_flag, m_valid;
  logic [7:0] m_tmo, m_cnt, m_rdata;
  int m_pcnt;

  always #4 clk = ~clk;

  kwdt_top #(.PULSE_CYCLES(PULSE)) u_kwdt_top (
    .clk(clk), .sb_rst_n(sb_rst_n), .sys_rst_n(sys_rst_n), .tick(tick),
    .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd),
    .bus_rdata(rdata), .wdt_rst_out(rst_out)
  );

  function automatic logic [7:0] b_stat(input logic e, input logic f);
    return (f ? 8'd2 : 8'd0) + (e ? 8'd1 : 8'd0);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_flag = 0; m_valid = 0; m_tmo = 0; m_cnt = 0; m_rdata = 0; m_pcnt = 0;
  endtask

  task automatic model_update(input logic [1:0] a, input logic [7:0] d,
                              input logic w, input logic r, input logic t);
    logic arm, dis, stale, tfire, boom;
    arm   = w && a == 2'd0 && d == 8'h55 && !m_en;
    dis   = w && a == 2'd0 && d == 8'hAA;
    stale = !m_valid || m_tmo == 8'd0;
    tfire = m_en && t && !dis && m_cnt == 8'd1;
    boom  = (arm && stale) || tfire;
    if (r) begin
      if (a == 2'd0) m_rdata = b_stat(m_en, 1'b0);
      else if (a == 2'd1) m_rdata = m_tmo;
      else if (a == 2'd2) m_rdata = b_stat(m_en, m_flag);
      else m_rdata = m_cnt;
    end
    if (boom) m_pcnt = PULSE; else if (m_pcnt > 0) m_pcnt--;
    if (boom) m_cnt = 0;
    else if (arm) m_cnt = m_tmo;
    else if (m_en && t && !dis && m_cnt != 0) m_cnt = m_cnt - 8'd1;
    if (boom) m_flag = 1; else if (r && a == 2'd2) m_flag = 0;
    if (boom) m_en = 0; else if (arm) m_en = 1; else if (dis) m_en = 0;
    if (boom) m_valid = 0; else if (w && a == 2'd1) m_valid = 1;
    if (w && a == 2'd1) m_tmo = d;
  endtask

  task automatic step(input logic [1:0] a, input logic [7:0] d,
                      input logic w, input logic r, input logic t);
    addr = a; wdata = d; wr = w; rd = r; tick = t;
    @(posedge clk); #1;
    model_update(a, d, w, r, t);
    @(negedge clk);
    wr = 0; rd = 0; tick = 0;
    chk("R8 pulse", {7'b0, rst_out}, {7'b0, m_pcnt != 0});
    chk("R12 rdata", rdata, m_rdata);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'd0, 8'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    step(a, 8'd0, 1'b0, 1'b1, 1'b0);
    chk(tag, rdata, exp);
  endtask

  task automatic standby_reset();
    @(negedge clk); sb_rst_n = 0; sys_rst_n = 0;
    repeat (2) @(negedge clk);
    model_reset();
    sb_rst_n = 1; sys_rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    standby_reset();
    chk("R11 reset out", {7'b0, rst_out}, 8'd0);
    rd_chk(2'd2, 8'd0, "R11 reset status");

    step(2'd1, 8'd3, 1, 0, 0);
    step(2'd0, 8'h55, 1, 0, 0);
    rd_chk(2'd3, 8'd3, "R3 load");
    rd_chk(2'd2, 8'd1, "R1 armed");
    rd_chk(2'd0, 8'd1, "R1 ctrl read");

    step(2'd0, 8'h12, 1, 0, 0);
    rd_chk(2'd2, 8'd1, "R2 junk");
    step(2'd0, 8'h00, 1, 0, 0);
    rd_chk(2'd2, 8'd1, "R2 zero");

    step(2'd0, 8'hAA, 1, 0, 0);
    rd_chk(2'd2, 8'd0, "R1 disarm");
    step(2'd0, 8'h55, 1, 0, 0);
    step(2'd0, 8'hAA, 1, 0, 0);
    step(2'd0, 8'h55, 1, 0, 0);
    rd_chk(2'd2, 8'd1, "R1 last key");

    step(2'd0, 8'd0, 0, 0, 1);
    rd_chk(2'd3, 8'd2, "R4 dec");
    step(2'd1, 8'd9, 1, 0, 0);
    rd_chk(2'd3, 8'd2, "R5 no reload");
    rd_chk(2'd1, 8'd9, "R5 tmo");
    step(2'd0, 8'h55, 1, 0, 0);
    rd_chk(2'd3, 8'd2, "R6 rearm");

    step(2'd0, 8'd0, 0, 0, 1);
    step(2'd0, 8'd0, 0, 0, 1);
    chk("R4 expire", {7'b0, rst_out}, 8'd1);
    rd_chk(2'd2, 8'd2, "R8 flag");
    rd_chk(2'd2, 8'd0, "R9 clear");
    idle(1);
    chk("R8 length", {7'b0, rst_out}, 8'd1);
    idle(1);
    chk("R8 end", {7'b0, rst_out}, 8'd0);

    step(2'd0, 8'h55, 1, 0, 0);
    chk("R7 stale", {7'b0, rst_out}, 8'd1);
    rd_chk(2'd2, 8'd2, "R7 stale flag");
    idle(4);
    step(2'd1, 8'd0, 1, 0, 0);
    step(2'd0, 8'h55, 1, 0, 0);
    chk("R7 zero", {7'b0, rst_out}, 8'd1);
    rd_chk(2'd2, 8'd2, "R7 zero flag");
    rd_chk(2'd2, 8'd0, "R9 clear2");
    idle(4);

    step(2'd1, 8'd1, 1, 0, 0);
    step(2'd0, 8'h55, 1, 0, 0);
    step(2'd0, 8'hAA, 1, 0, 1);
    chk("R10 no pulse", {7'b0, rst_out}, 8'd0);
    rd_chk(2'd2, 8'd0, "R10 status");

    step(2'd0, 8'h55, 1, 0, 0);
    step(2'd2, 8'd0, 0, 1, 1);
    chk("R9 same cycle read", rdata, 8'd1);
    idle(4);

    step(2'd1, 8'd5, 1, 0, 0);
    step(2'd0, 8'h55, 1, 0, 0);
    rd_chk(2'd1, 8'd5, "R12 read");
    idle(2);
    chk("R12 hold", rdata, 8'd5);
    @(negedge clk); sys_rst_n = 0;
    @(negedge clk); sys_rst_n = 1; m_rdata = 0;
    chk("R11 main rdata", rdata, 8'd0);
    rd_chk(2'd2, 8'd3, "R11 en+flag kept");
    rd_chk(2'd1, 8'd5, "R11 tmo kept");
    rd_chk(2'd3, 8'd5, "R11 cnt kept");
    standby_reset();
    rd_chk(2'd2, 8'd0, "R11 sb status");
    rd_chk(2'd1, 8'd0, "R11 sb tmo");
    step(2'd0, 8'h55, 1, 0, 0);
    chk("R7 after sb", {7'b0, rst_out}, 8'd1);

    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [7:0] d;
      logic t;
      op = $urandom_range(0, 9);
      t = ($urandom_range(0, 2) == 0);
      if (op < 3) begin
        d = ($urandom_range(0, 2) == 0) ? 8'h55 : ($urandom_range(0, 1) ? 8'hAA : 8'($urandom));
        step(2'd0, d, 1, 0, t);
      end else if (op < 5) begin
        step(2'd1, 8'($urandom_range(0, 5)), 1, 0, t);
      end else if (op < 8) begin
        step(2'($urandom_range(0, 3)), 8'd0, 0, 1, t);
      end else begin
        step(2'd0, 8'd0, 0, 0, t);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule